// File: doc/BRIEF.md
# Selective-Capture Status Register with Interrupt Mask

This block gathers up to eight condition inputs into one status byte for a host processor. Each bit position is fixed at build time as either latched or real-time. A latched position records a one-cycle event pulse and holds it until the host collects it. A real-time position simply mirrors its input level and keeps no history. A separate mask byte decides which positions may pull the active-low interrupt output low.

The host works through a plain parallel bus with a 2-bit address, a write strobe and a read strobe. A write to the status address is a per-bit capture request, not a data store. For each bit written as one, the pending flag is copied into a held snapshot and the flag is cleared. For each bit written as zero, both the snapshot and the flag are left alone. A read of the status address returns the snapshot for latched positions and the live level for real-time positions.

A polling host writes a mask, reads the snapshot, then writes back the value read ANDed with the mask. That last write clears any flag that was set again by an event during the capture. Event pulses are never lost: a pulse in the same cycle as a clearing write leaves the flag set.

Top module: `stat_capture_regs`

## Requirements
- R1: After reset, reads of address 0, 1 and 2 return 0x00 and `irq_n` is high.
- R2: A one-cycle pulse on a latched position's `evt_in` bit sets its pending flag. The flag stays set, through any number of cycles, until a capture write selects that bit. Pending flags are read at address 2.
- R3: A write to address 0 with a bit set to one loads that bit of the snapshot with its pending flag's value before the write, and clears the pending flag.
- R4: A write to address 0 with a bit set to zero leaves that bit's snapshot value and pending flag unchanged.
- R5: A read of address 0 returns the snapshot on latched positions and the current `evt_in` level on real-time positions. The default build makes bits 7 and 6 real-time and bits 5 to 0 latched.
- R6: Real-time positions keep no history: address 2 always reads zero there, writes to address 0 have no effect on them, and a real-time bit reads zero once its input returns low.
- R7: An event pulse in the same cycle as a capture write selecting its bit leaves the pending flag set. A second capture write then clears it.
- R8: Address 1 is the interrupt mask, readable and writable as a byte. Bit i enables status position i.
- R9: `irq_n` goes low one cycle after any enabled pending flag or any enabled high real-time input exists, and is high one cycle after none does.
- R10: A read of address 3 returns 0x00. Read data appears on `rdata` in the cycle after the clock edge that sampled `rd_en`, and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Active-low synchronous reset that clears every register |
| evt_in | input | 8 | Event pulses (latched positions) or live condition levels (real-time positions) |
| wr_en | input | 1 | Single-cycle host write strobe |
| rd_en | input | 1 | Single-cycle host read strobe |
| addr | input | 2 | Register select: 0 status/capture, 1 interrupt mask, 2 pending flags, 3 unused |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The event input and the host's capture write can land on the same bit in the same clock cycle. The bench provokes this by driving an event pulse on bit 1 and a capture write selecting bit 1 in one cycle. It then reads the pending flags and expects bit 1 to still be set, and expects a snapshot of zero for that bit, since the flag was clear before the write. A second capture write must then move the flag into the snapshot and clear it, which the bench confirms by reading both addresses again.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int STAT_W = 8;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_IMASK  = 2'd1,
    ADDR_PEND   = 2'd2,
    ADDR_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/stat_latch_bank.sv
module stat_latch_bank #(
  parameter int          W         = 8,
  parameter logic [W-1:0] LATCH_MAP = 8'h3F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr_sel,
  output logic [W-1:0] pend,
  output logic [W-1:0] snap
);
  logic [W-1:0] pend_q, snap_q;
  logic [W-1:0] pend_d, snap_d;

  // The new event is OR-ed in after the clear, so a coincident pulse survives.
  always_comb begin
    pend_d = ((pend_q & ~clr_sel) | evt) & LATCH_MAP;
    snap_d = ((clr_sel & pend_q) | (~clr_sel & snap_q)) & LATCH_MAP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      snap_q <= '0;
    end else begin
      pend_q <= pend_d;
      snap_q <= snap_d;
    end
  end

  assign pend = pend_q;
  assign snap = snap_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    if (LATCH_MAP[i]) begin : g_lat
      a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> pend_q[i]);
      a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && !clr_sel[i]) |=> pend_q[i]);
      a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sel[i] |=> (snap_q[i] == $past(pend_q[i])));
      a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel[i] && !evt[i]) |=> !pend_q[i]);
      a_r4_snap_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_sel[i] |=> $stable(snap_q[i]));
      a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel[i] && evt[i]) |=> pend_q[i]);
    end
  end
endmodule

// File: rtl/stat_irq_gen.sv
module stat_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] live,
  input  logic [W-1:0] imask,
  output logic         irq_n
);
  logic any_src;
  logic irq_n_q;

  assign any_src = |((pend | live) & imask);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= ~any_src;
  end

  assign irq_n = irq_n_q;

  a_r9_assert: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> !irq_n_q);
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    !any_src |=> irq_n_q);
endmodule

// File: rtl/stat_host_port.sv
module stat_host_port
  import stat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] status_view,
  input  logic [W-1:0] pend_view,
  output logic [W-1:0] clr_sel,
  output logic [W-1:0] imask,
  output logic [W-1:0] rdata
);
  reg_addr_e    sel;
  logic [W-1:0] imask_q, rdata_q, rd_mux;

  assign sel     = reg_addr_e'(addr);
  assign clr_sel = (wr_en && sel == ADDR_STATUS) ? wdata : '0;

  always_comb begin
    unique case (sel)
      ADDR_STATUS: rd_mux = status_view;
      ADDR_IMASK:  rd_mux = imask_q;
      ADDR_PEND:   rd_mux = pend_view;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imask_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && sel == ADDR_IMASK) imask_q <= wdata;
      if (rd_en)                      rdata_q <= rd_mux;
    end
  end

  assign imask = imask_q;
  assign rdata = rdata_q;

  a_r8_imask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == ADDR_IMASK) |=> (imask_q == $past(wdata)));
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == ADDR_NONE) |=> (rdata_q == '0));
endmodule

// File: rtl/stat_capture_regs.sv
module stat_capture_regs
  import stat_pkg::*;
#(
  parameter logic [STAT_W-1:0] LATCH_MAP = 8'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] rdata,
  output logic              irq_n
);
  localparam logic [STAT_W-1:0] LIVE_MAP = ~LATCH_MAP;

  logic [STAT_W-1:0] clr_sel, pend, snap, imask, live, status_view;

  assign live        = evt_in & LIVE_MAP;
  assign status_view = (snap & LATCH_MAP) | live;

  stat_latch_bank #(.W(STAT_W), .LATCH_MAP(LATCH_MAP)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_in),
    .clr_sel (clr_sel),
    .pend    (pend),
    .snap    (snap)
  );

  stat_host_port #(.W(STAT_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .status_view (status_view),
    .pend_view   (pend),
    .clr_sel     (clr_sel),
    .imask       (imask),
    .rdata       (rdata)
  );

  stat_irq_gen #(.W(STAT_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .live  (live),
    .imask (imask),
    .irq_n (irq_n)
  );
endmodule

// File: tb/stat_capture_regs_test.sv
`timescale 1ns/1ps
module stat_capture_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_in = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;

  logic [7:0] rt_lvl = '0;
  logic       rd_d = 1'b0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  stat_capture_regs uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  always @(posedge clk) rd_d <= rd_en;

  // Monitor: compares each read result against the scoreboard entry.
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected read data %02h, expected none", rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (rdata !== e.val) begin
          errors++;
          $display("FAIL %s: read %02h expected %02h", e.tag, rdata, e.val);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    exp_q.push_back(e);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] bits);
    evt_in = bits | rt_lvl;
    @(negedge clk);
    evt_in = rt_lvl;
  endtask

  task automatic set_rt(input logic [7:0] lvl);
    rt_lvl = lvl;
    evt_in = lvl;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq_n !== exp) begin
      errors++;
      $display("FAIL %s: irq_n %0b expected %0b", tag, irq_n, exp);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    checks++;
    if (irq_n !== 1'b1) begin
      errors++;
      $display("FAIL R1: irq_n %0b expected 1", irq_n);
    end
    rd(2'd0, 8'h00, "R1 status");
    rd(2'd1, 8'h00, "R1 imask");
    rd(2'd2, 8'h00, "R1 pend");

    // R2 latching and holding
    pulse(8'h05);
    repeat (4) @(negedge clk);
    rd(2'd2, 8'h05, "R2 pend held");

    // R3 / R4 selective capture
    wr(2'd0, 8'h01);
    rd(2'd0, 8'h01, "R3 snapshot bit0");
    rd(2'd2, 8'h04, "R4 bit2 untouched");
    wr(2'd0, 8'h04);
    rd(2'd0, 8'h05, "R4 bit0 snapshot kept");
    rd(2'd2, 8'h00, "R3 bit2 cleared");
    wr(2'd0, 8'h01);
    rd(2'd0, 8'h04, "R3 recapture of clear flag");

    // R5 / R6 real-time positions
    set_rt(8'h80);
    rd(2'd0, 8'h84, "R5 live bit7");
    rd(2'd2, 8'h00, "R6 no pend on real-time");
    wr(2'd0, 8'hC0);
    rd(2'd0, 8'h84, "R6 write ignored");
    set_rt(8'h00);
    rd(2'd0, 8'h04, "R6 no history");

    // R7 event coincident with clearing write
    evt_in = 8'h02;
    wr(2'd0, 8'h02);
    evt_in = 8'h00;
    rd(2'd2, 8'h02, "R7 event survives clear");
    rd(2'd0, 8'h04, "R7 snapshot took old flag");
    wr(2'd0, 8'h02);
    rd(2'd2, 8'h00, "R7 second write clears");
    rd(2'd0, 8'h06, "R7 second capture");

    // R8 interrupt mask
    wr(2'd1, 8'hA5);
    rd(2'd1, 8'hA5, "R8 imask readback");
    wr(2'd1, 8'h00);

    // R9 interrupt generation
    pulse(8'h08);
    chk_irq(1'b1, "R9 masked pending");
    wr(2'd1, 8'h08);
    chk_irq(1'b0, "R9 enabled pending");
    wr(2'd0, 8'h08);
    chk_irq(1'b1, "R9 released after capture");
    wr(2'd1, 8'h80);
    set_rt(8'h80);
    chk_irq(1'b0, "R9 real-time asserts");
    set_rt(8'h00);
    chk_irq(1'b1, "R9 real-time releases");

    // R10 unused address and held read data
    rd(2'd3, 8'h00, "R10 unused address");
    repeat (2) @(negedge clk);
    checks++;
    if (rdata !== 8'h00) begin
      errors++;
      $display("FAIL R10: held rdata %02h expected 00", rdata);
    end

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule